// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides, every cycle, which of up to `NUM_THREADS` hardware threads may use the instruction fetch path. Each thread presents a 3-bit fetch state and an active bit. A thread can be picked only if it is active and its state is one of three fetchable states. A policy input chooses between a fixed single-thread mode and a rotating mode. In rotating mode an ordered list of thread IDs is scanned from head to tail. The first eligible thread wins and is then moved to the tail of the list.

The grant is combinational from the current list and the current eligibility. The list itself changes only at the clock edge after a cycle with a valid grant. A drain request blocks every grant while it is held. The grant is a per-cycle control output with no ready input: the fetch path either uses the grant in that cycle or drops it. A dropped grant still rotates the list.

Top module: `fetch_thread_sel`

## Requirements
- R1: A thread is eligible only when its bit in `active_i` is 1 and its state field (`status_i[3*t+2:3*t]`) is 0 (running), 1 (line returned) or 2 (idle). Codes 3 to 7 (blocked, squashing, awaiting response, awaiting retry, trap pending) make the thread ineligible.
- R2: When `policy_i`=1 (rotating), `drain_i`=0 and at least one thread is eligible, `pick_valid_o` is 1. `pick_id_o` is the eligible thread found nearest the head of the list.
- R3: After a valid grant, the granted ID moves to the tail of the list. All other IDs keep their relative order.
- R4: When no thread is eligible, `pick_valid_o` is 0 and the list is unchanged.
- R5: While `drain_i`=1, `pick_valid_o` is 0 and the list is unchanged, whatever the eligibility.
- R6: Reset sets the list to ascending thread ID, 0 at the head. With every thread eligible, the grants after reset are therefore 0, 1, 2, ... in turn.
- R7: With `NUM_THREADS`=1 the policy is ignored. Thread 0 is granted whenever it is eligible and `drain_i`=0, and `cfg_err_o` stays 0.
- R8: With `NUM_THREADS`>1, `policy_i`=0 (single-thread) is an illegal setting. In that case `cfg_err_o`=1, `pick_valid_o`=0 and the list is unchanged.
- R9: `pick_valid_o` and `pick_id_o` follow changes on `status_i` and `active_i` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_i | input | 1 | 0 single-thread, 1 rotating |
| drain_i | input | 1 | Blocks all grants while 1 |
| active_i | input | NUM_THREADS | Active mask, one bit per thread |
| status_i | input | 3*NUM_THREADS | Fetch state per thread, thread t in bits 3t+2..3t |
| pick_valid_o | output | 1 | A thread is granted this cycle |
| pick_id_o | output | IDW | Granted thread ID |
| cfg_err_o | output | 1 | Illegal policy for the configured thread count |

## Verification
A drain request or an illegal policy can arrive in the same cycle in which an eligible thread sits at the head of the list. The list must then keep its order even though a grant would otherwise rotate it. The bench produces this by pulsing `drain_i` and clearing `policy_i` at random over random eligibility patterns. A behavioural queue model predicts each cycle's grant, and the bench compares against it every clock. A later grant that comes from the wrong position shows that the list moved when it should not have.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_RUN     = 3'd0,
    ST_LINE_OK = 3'd1,
    ST_IDLE    = 3'd2,
    ST_BLOCK   = 3'd3,
    ST_SQUASH  = 3'd4,
    ST_WAITRSP = 3'd5,
    ST_WAITRTY = 3'd6,
    ST_TRAP    = 3'd7
  } fetch_state_e;

  localparam logic POL_SINGLE = 1'b0;
  localparam logic POL_ROTATE = 1'b1;

  function automatic logic is_fetchable(fetch_state_e s);
    return (s == ST_RUN) || (s == ST_LINE_OK) || (s == ST_IDLE);
  endfunction
endpackage

// File: rtl/fsel_elig.sv
module fsel_elig
  import fsel_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0]         active_i,
  input  logic [N*STATE_W-1:0] status_i,
  output logic [N-1:0]         elig_o
);
  for (genvar gi = 0; gi < N; gi++) begin : g_thr
    fetch_state_e st;
    assign st         = fetch_state_e'(status_i[gi*STATE_W +: STATE_W]);
    assign elig_o[gi] = active_i[gi] & is_fetchable(st);
  end
endmodule

// File: rtl/fsel_rr_list.sv
module fsel_rr_list #(
  parameter int N   = 4,
  parameter int IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   elig_i,
  input  logic           en_i,
  output logic           pick_valid_o,
  output logic [IDW-1:0] pick_id_o
);
  localparam int SPAN = 1 << IDW;

  logic [IDW-1:0] lst_q [N];
  logic [IDW-1:0] lst_d [N];
  logic           hit;
  logic [IDW-1:0] pos;

  // scan from head to tail for the first eligible ID
  always_comb begin
    hit = 1'b0;
    pos = '0;
    for (int i = 0; i < N; i++) begin
      if (!hit && elig_i[lst_q[i]]) begin
        hit = 1'b1;
        pos = IDW'(i);
      end
    end
  end

  assign pick_valid_o = hit & en_i;
  assign pick_id_o    = lst_q[pos];

  // close the gap at pos, append the granted ID at the tail
  for (genvar gi = 0; gi < N; gi++) begin : g_next
    if (gi == N - 1) begin : g_tail
      assign lst_d[gi] = pick_id_o;
    end else begin : g_body
      assign lst_d[gi] = (gi < int'(pos)) ? lst_q[gi] : lst_q[gi+1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) lst_q[i] <= IDW'(i);
    end else if (pick_valid_o) begin
      for (int i = 0; i < N; i++) lst_q[i] <= lst_d[i];
    end
  end

  logic [N*IDW-1:0] lst_flat;
  logic [SPAN-1:0]  seen;
  always_comb begin
    seen = '0;
    for (int i = 0; i < N; i++) begin
      lst_flat[i*IDW +: IDW] = lst_q[i];
      seen[lst_q[i]]         = 1'b1;
    end
  end

  // R3: the granted ID lands at the tail
  a_r3_tail_is_pick: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid_o |=> (lst_q[N-1] == $past(pick_id_o)));
  // R3: the list always holds each ID exactly once
  a_r3_permutation: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seen) == N);
  // R4 / R5 / R8: no grant, no movement
  a_r4_hold_list: assert property (@(posedge clk) disable iff (!rst_n)
    !pick_valid_o |=> $stable(lst_flat));
  // R2: the grant goes to an eligible thread
  a_r2_pick_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid_o |-> elig_i[pick_id_o]);
endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel
  import fsel_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int IDW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           policy_i,
  input  logic                           drain_i,
  input  logic [NUM_THREADS-1:0]         active_i,
  input  logic [NUM_THREADS*STATE_W-1:0] status_i,
  output logic                           pick_valid_o,
  output logic [IDW-1:0]                 pick_id_o,
  output logic                           cfg_err_o
);
  logic [NUM_THREADS-1:0] elig;

  fsel_elig #(.N(NUM_THREADS)) u_elig (
    .active_i (active_i),
    .status_i (status_i),
    .elig_o   (elig)
  );

  if (NUM_THREADS == 1) begin : g_single
    assign pick_valid_o = elig[0] & ~drain_i;
    assign pick_id_o    = '0;
    assign cfg_err_o    = 1'b0;
  end else begin : g_multi
    logic en;
    assign cfg_err_o = (policy_i == POL_SINGLE);
    assign en        = ~drain_i & (policy_i == POL_ROTATE);

    fsel_rr_list #(.N(NUM_THREADS), .IDW(IDW)) u_list (
      .clk          (clk),
      .rst_n        (rst_n),
      .elig_i       (elig),
      .en_i         (en),
      .pick_valid_o (pick_valid_o),
      .pick_id_o    (pick_id_o)
    );
  end

  // R1: a granted thread is active and in a fetchable state
  a_r1_grant_fetchable: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid_o |-> (active_i[pick_id_o] &&
      (status_i[pick_id_o*STATE_W +: STATE_W] <= 3'd2)));
  // R5: drain blocks all grants
  a_r5_drain_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    drain_i |-> !pick_valid_o);
  // R8: illegal policy raises the flag and blocks grants
  a_r8_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |-> !pick_valid_o);
endmodule

// File: tb/tb_fetch_thread_sel.sv
module tb_fetch_thread_sel;
  localparam int CLK_P = 10;
  localparam int N     = 4;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic         rst_n, pol, drain;
  logic [N-1:0] act;
  logic [3*N-1:0] st;
  logic         act1;
  logic [2:0]   st1;
  logic         v, err, v1, err1;
  logic [1:0]   id;
  logic [0:0]   id1;

  fetch_thread_sel #(.NUM_THREADS(N)) dut (
    .clk(clk), .rst_n(rst_n), .policy_i(pol), .drain_i(drain),
    .active_i(act), .status_i(st),
    .pick_valid_o(v), .pick_id_o(id), .cfg_err_o(err));

  fetch_thread_sel #(.NUM_THREADS(1)) dut_one (
    .clk(clk), .rst_n(rst_n), .policy_i(pol), .drain_i(drain),
    .active_i(act1), .status_i(st1),
    .pick_valid_o(v1), .pick_id_o(id1), .cfg_err_o(err1));

  int q[$];
  int checks = 0, bad = 0;
  bit exp_v, exp_err, finished = 0;
  int exp_id, exp_idx;

  function automatic bit elig(int t);
    return act[t] && (st[t*3 +: 3] < 3'd3);
  endfunction

  task automatic cmp(string tag, string what, logic [31:0] a, logic [31:0] e);
    checks++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, a, e, $time);
    end
  endtask

  task automatic model_eval();
    exp_err = (pol == 1'b0);
    exp_v   = 0;
    exp_idx = -1;
    exp_id  = 0;
    if (!drain && pol) begin
      foreach (q[k]) begin
        if (exp_idx < 0 && elig(q[k])) begin
          exp_idx = k; exp_v = 1; exp_id = q[k];
        end
      end
    end
  endtask

  task automatic check(string tag);
    bit e1;
    model_eval();
    cmp(tag, "valid", 32'(v), 32'(exp_v));
    if (exp_v) cmp(tag, "id", 32'(id), 32'(exp_id));
    cmp(tag, "cfg_err", 32'(err), 32'(exp_err));
    e1 = act1 && (st1 < 3'd3) && !drain;
    cmp("R7", "valid_one", 32'(v1), 32'(e1));
    if (e1) cmp("R7", "id_one", 32'(id1), 32'd0);
    cmp("R7", "cfg_err_one", 32'(err1), 32'd0);
  endtask

  task automatic step(string tag);
    #1 check(tag);
    @(posedge clk);
    if (exp_v) begin
      q.delete(exp_idx);
      q.push_back(exp_id);
    end
    @(negedge clk);
  endtask

  function automatic string auto_tag();
    bit any = 0;
    for (int t = 0; t < N; t++) any |= elig(t);
    if (drain) return "R5";
    if (!pol) return "R8";
    if (!any) return "R4";
    return "R2 R3";
  endfunction

  task automatic set_all(logic [2:0] code);
    for (int t = 0; t < N; t++) st[t*3 +: 3] = code;
  endtask

  initial begin
    rst_n = 0; pol = 1; drain = 0; act = '1; st = '0; act1 = 1; st1 = 0;
    for (int t = 0; t < N; t++) q.push_back(t);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R6: ascending order after reset
    for (int k = 0; k < N; k++) step("R6");

    // R1: every state code, plus inactive threads
    for (int c = 0; c < 8; c++) begin
      set_all(3'(c)); st1 = 3'(c);
      step("R1");
    end
    set_all(3'd0); act = '0; act1 = 0;
    step("R1");
    act = '1; act1 = 1;

    // R3: only 0 and 2 eligible, then all: 1 and 3 kept their places
    set_all(3'd3); st[0 +: 3] = 3'd1; st[6 +: 3] = 3'd2;
    for (int k = 0; k < 3; k++) step("R3");
    set_all(3'd0);
    for (int k = 0; k < N; k++) step("R3");

    // R9: same-cycle response to eligibility changes
    set_all(3'd4); st[3 +: 3] = 3'd0;
    #1 check("R9");
    st[3 +: 3] = 3'd4; st[9 +: 3] = 3'd2;
    step("R9");

    // R5: drain over eligible threads, then release
    set_all(3'd0); drain = 1;
    step("R5"); step("R5");
    drain = 0;
    step("R5");

    // R4: nothing eligible
    set_all(3'd5);
    step("R4"); step("R4");

    // R8: illegal single-thread policy
    set_all(3'd0); pol = 0;
    step("R8"); step("R8");
    pol = 1;
    step("R8");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      st    = 12'($urandom);
      act   = 4'($urandom);
      drain = ($urandom % 8) == 0;
      pol   = ($urandom % 10) != 0;
      act1  = 1'($urandom);
      st1   = 3'($urandom);
      step(auto_tag());
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule